// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block holds the digital divider chain of an integer-N synthesizer loop. On the fast input clock, a prescaler divides by 10 or by 11. A modulus-select signal picks between the two. That signal comes from a 4-bit swallow counter and a 9-bit main counter. Together they give a total division of 10·(M+1)+A input clocks for each main output pulse. When the prescaler is switched off, the input clock drives the main counter directly and the ratio becomes M+1. On a separate reference clock, a 6-bit counter divides by R+1 to make the comparison pulse.

Both divided outputs are single-cycle pulses in their own clock domains. The modulus-select level is brought out so that the swallow phase can be watched. A direct-mode flag forces the two upper bits of M and of R to zero, which narrows the ranges to M in 1..127 and R in 0..15. Divide values are sampled only at the terminal count of their own counter. A change therefore applies from the next full output period onward.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With `presc_en_n` low, consecutive `main_pulse` assertions are exactly 10·(M+1)+A `clk_in` cycles apart, for legal settings (1 ≤ M ≤ 511, 0 ≤ A ≤ 15, A ≤ M+1), including the largest setting M=511, A=15 (5135 cycles) and the edge A=M+1.
- R2: Within each main period, `mod_sel` is high for exactly 11·A `clk_in` cycles, which are the first A prescaler periods, and low for the other cycles.
- R3: The smallest setting, M=1, makes the main counter divide the prescaler output by 2: 20 input clocks with A=0 and the prescaler on, and 2 input clocks in bypass.
- R4: With `presc_en_n` high, the period is M+1 `clk_in` cycles, A has no effect, and `mod_sel` stays low.
- R5: Consecutive `ref_pulse` assertions are R+1 `ref_clk` cycles apart for 0 ≤ R ≤ 63. With R=0, `ref_pulse` is high on every `ref_clk` cycle.
- R6: With `direct_mode` high, bits 8:7 of `m_val` and bits 5:4 of `r_val` are treated as zero, for example M=300 acts as 44 and R=50 acts as 2.
- R7: New M, A, R, `presc_en_n` and `direct_mode` values are taken only at the terminal count. An output period that is running when the inputs change finishes with the old values, and the next period uses the new ones.
- R8: While `rst_n` is low, `main_pulse`, `ref_pulse` and `mod_sel` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock (divided by the main chain) |
| ref_clk | input | 1 | Reference clock (divided by the reference counter) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| m_val | input | 9 | Main counter value M |
| a_val | input | 4 | Swallow counter value A |
| r_val | input | 6 | Reference counter value R |
| presc_en_n | input | 1 | Prescaler enable, active low; high selects bypass |
| direct_mode | input | 1 | Forces M[8:7] and R[5:4] to zero |
| main_pulse | output | 1 | One `clk_in` cycle pulse per main period |
| ref_pulse | output | 1 | One `ref_clk` cycle pulse per reference period |
| mod_sel | output | 1 | Modulus-select monitor: high while the prescaler divides by 11 |

## Verification
Some properties are checked on every cycle. A main pulse always coincides with the prescaler and main counters being back at zero. The prescaler, swallow, main and reference counters stay within their loaded limits. `mod_sel` stays low in bypass. A period running with the prescaler on never produces back-to-back pulses. The direct-mode masking is visible in the loaded values. Other behaviour can only be shown by the bench's scenarios, which count clocks between pulses: the exact period formulas, the 11·A length of the swallow phase, that A is ignored in bypass, and that a period running when the inputs change finishes with its old ratio.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // default widths of the divide values
  localparam int unsigned PSD_M_W    = 9;
  localparam int unsigned PSD_A_W    = 4;
  localparam int unsigned PSD_R_W    = 6;
  // low modulus of the dual-modulus prescaler (high modulus is one more)
  localparam int unsigned PSD_PRE_LO = 10;

  // prescaler operating mode chosen by the swallow control
  typedef enum logic [1:0] {
    PS_BYPASS  = 2'd0,
    PS_DIV_LO  = 2'd1,
    PS_DIV_HI  = 2'd2
  } ps_mode_e;
endpackage

// File: rtl/psd_reset_sync.sv
module psd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned PRE_LO = PSD_PRE_LO,
  localparam int unsigned CW    = $clog2(PRE_LO + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  ps_mode_e      mode,
  output logic          tick,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] limit;

  // last count value of the current prescaler period
  always_comb begin
    unique case (mode)
      PS_BYPASS: limit = '0;
      PS_DIV_HI: limit = CW'(PRE_LO);
      default:   limit = CW'(PRE_LO - 1);
    endcase
  end

  assign tick = (cnt_q == limit);

  always_comb begin
    if (clr || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl
  import psd_pkg::*;
#(
  parameter int unsigned M_W = PSD_M_W,
  parameter int unsigned A_W = PSD_A_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           bypass_in,
  input  logic           direct_in,
  input  logic           tick,
  output ps_mode_e       mode,
  output logic           presc_clr,
  output logic           mod_sel,
  output logic           pulse,
  output logic [M_W-1:0] m_cur,
  output logic [A_W-1:0] a_cur,
  output logic           bypass_cur,
  output logic           direct_cur,
  output logic [M_W-1:0] mc_o,
  output logic [A_W-1:0] sw_o
);
  localparam int unsigned M_KEEP = M_W - 2;

  logic           armed_q,  armed_d;
  logic [M_W-1:0] m_cur_q,  m_cur_d;
  logic [A_W-1:0] a_cur_q,  a_cur_d;
  logic           byp_q,    byp_d;
  logic           dir_q,    dir_d;
  logic [M_W-1:0] mc_q,     mc_d;
  logic [A_W-1:0] sw_q,     sw_d;
  logic           pulse_q,  pulse_d;
  logic [M_W-1:0] m_masked;
  logic           term;
  logic           load_en;

  // direct mode clears the two upper bits of M
  assign m_masked = direct_in ? {2'b00, m_in[M_KEEP-1:0]} : m_in;

  assign mod_sel   = !byp_q && (sw_q < a_cur_q);
  assign term      = tick && (mc_q == m_cur_q);
  assign load_en   = !armed_q || term;
  assign presc_clr = !armed_q;

  always_comb begin
    if (byp_q) begin
      mode = PS_BYPASS;
    end else if (mod_sel) begin
      mode = PS_DIV_HI;
    end else begin
      mode = PS_DIV_LO;
    end
  end

  always_comb begin
    armed_d = 1'b1;
    m_cur_d = m_cur_q;
    a_cur_d = a_cur_q;
    byp_d   = byp_q;
    dir_d   = dir_q;
    mc_d    = mc_q;
    sw_d    = sw_q;
    pulse_d = armed_q && term;
    if (load_en) begin
      m_cur_d = m_masked;
      a_cur_d = a_in;
      byp_d   = bypass_in;
      dir_d   = direct_in;
      mc_d    = '0;
      sw_d    = '0;
    end else if (tick) begin
      mc_d = mc_q + 1'b1;
      if (sw_q < a_cur_q) begin
        sw_d = sw_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      m_cur_q <= '0;
      a_cur_q <= '0;
      byp_q   <= 1'b0;
      dir_q   <= 1'b0;
      mc_q    <= '0;
      sw_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      m_cur_q <= m_cur_d;
      a_cur_q <= a_cur_d;
      byp_q   <= byp_d;
      dir_q   <= dir_d;
      mc_q    <= mc_d;
      sw_q    <= sw_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse      = pulse_q;
  assign m_cur      = m_cur_q;
  assign a_cur      = a_cur_q;
  assign bypass_cur = byp_q;
  assign direct_cur = dir_q;
  assign mc_o       = mc_q;
  assign sw_o       = sw_q;
endmodule

// File: rtl/psd_ref_divider.sv
module psd_ref_divider
  import psd_pkg::*;
#(
  parameter int unsigned R_W = PSD_R_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [R_W-1:0] r_in,
  input  logic           direct_in,
  output logic           pulse,
  output logic [R_W-1:0] r_cur,
  output logic           direct_cur,
  output logic [R_W-1:0] cnt_o
);
  localparam int unsigned R_KEEP = R_W - 2;

  logic           armed_q, armed_d;
  logic [R_W-1:0] r_cur_q, r_cur_d;
  logic           dir_q,   dir_d;
  logic [R_W-1:0] cnt_q,   cnt_d;
  logic           pulse_q, pulse_d;
  logic [R_W-1:0] r_masked;
  logic           term;
  logic           load_en;

  // direct mode clears the two upper bits of R
  assign r_masked = direct_in ? {2'b00, r_in[R_KEEP-1:0]} : r_in;
  assign term     = (cnt_q == r_cur_q);
  assign load_en  = !armed_q || term;

  always_comb begin
    armed_d = 1'b1;
    r_cur_d = r_cur_q;
    dir_d   = dir_q;
    pulse_d = armed_q && term;
    if (load_en) begin
      r_cur_d = r_masked;
      dir_d   = direct_in;
      cnt_d   = '0;
    end else begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      r_cur_q <= '0;
      dir_q   <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      r_cur_q <= r_cur_d;
      dir_q   <= dir_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse      = pulse_q;
  assign r_cur      = r_cur_q;
  assign direct_cur = dir_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter int unsigned M_W    = PSD_M_W,
  parameter int unsigned A_W    = PSD_A_W,
  parameter int unsigned R_W    = PSD_R_W,
  parameter int unsigned PRE_LO = PSD_PRE_LO,
  localparam int unsigned PC_W  = $clog2(PRE_LO + 1)
) (
  input  logic           clk_in,
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic [R_W-1:0] r_val,
  input  logic           presc_en_n,
  input  logic           direct_mode,
  output logic           main_pulse,
  output logic           ref_pulse,
  output logic           mod_sel
);
  logic            main_rst_n;
  logic            ref_rst_n;
  ps_mode_e        ps_mode;
  logic            ps_tick;
  logic            ps_clr;
  logic [PC_W-1:0] pc;
  logic [M_W-1:0]  m_cur;
  logic [A_W-1:0]  a_cur;
  logic            bypass_cur;
  logic            direct_cur;
  logic [M_W-1:0]  mc;
  logic [A_W-1:0]  sw;
  logic [R_W-1:0]  r_cur;
  logic            ref_direct_cur;
  logic [R_W-1:0]  rc;

  psd_reset_sync #(.STAGES(2)) u_main_rst (
    .clk    (clk_in),
    .arst_n (rst_n),
    .srst_n (main_rst_n)
  );

  psd_reset_sync #(.STAGES(2)) u_ref_rst (
    .clk    (ref_clk),
    .arst_n (rst_n),
    .srst_n (ref_rst_n)
  );

  psd_prescaler #(.PRE_LO(PRE_LO)) u_presc (
    .clk   (clk_in),
    .rst_n (main_rst_n),
    .clr   (ps_clr),
    .mode  (ps_mode),
    .tick  (ps_tick),
    .cnt_o (pc)
  );

  psd_swallow_ctrl #(.M_W(M_W), .A_W(A_W)) u_ctrl (
    .clk        (clk_in),
    .rst_n      (main_rst_n),
    .m_in       (m_val),
    .a_in       (a_val),
    .bypass_in  (presc_en_n),
    .direct_in  (direct_mode),
    .tick       (ps_tick),
    .mode       (ps_mode),
    .presc_clr  (ps_clr),
    .mod_sel    (mod_sel),
    .pulse      (main_pulse),
    .m_cur      (m_cur),
    .a_cur      (a_cur),
    .bypass_cur (bypass_cur),
    .direct_cur (direct_cur),
    .mc_o       (mc),
    .sw_o       (sw)
  );

  psd_ref_divider #(.R_W(R_W)) u_ref (
    .clk        (ref_clk),
    .rst_n      (ref_rst_n),
    .r_in       (r_val),
    .direct_in  (direct_mode),
    .pulse      (ref_pulse),
    .r_cur      (r_cur),
    .direct_cur (ref_direct_cur),
    .cnt_o      (rc)
  );
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int unsigned M_W    = 9,
  parameter int unsigned A_W    = 4,
  parameter int unsigned R_W    = 6,
  parameter int unsigned PRE_LO = 10,
  localparam int unsigned PC_W  = $clog2(PRE_LO + 1)
) (
  input logic            clk_in,
  input logic            ref_clk,
  input logic            main_rst_n,
  input logic            ref_rst_n,
  input logic            main_pulse,
  input logic            mod_sel,
  input logic            bypass_cur,
  input logic            direct_cur,
  input logic [M_W-1:0]  m_cur,
  input logic [A_W-1:0]  a_cur,
  input logic [M_W-1:0]  mc,
  input logic [A_W-1:0]  sw,
  input logic [PC_W-1:0] pc,
  input logic            ref_direct_cur,
  input logic [R_W-1:0]  r_cur,
  input logic [R_W-1:0]  rc
);
  AST_PULSE_AT_WRAP: assert property (@(posedge clk_in) disable iff (!main_rst_n)
    main_pulse |-> (pc == '0 && mc == '0)); // R1
  AST_PRESC_RANGE: assert property (@(posedge clk_in) disable iff (!main_rst_n)
    pc <= PC_W'(PRE_LO)); // R1
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_in) disable iff (!main_rst_n)
    (main_pulse && !bypass_cur) |=> !main_pulse); // R1
  AST_SWALLOW_BOUND: assert property (@(posedge clk_in) disable iff (!main_rst_n)
    sw <= a_cur); // R2
  AST_MAIN_BOUND: assert property (@(posedge clk_in) disable iff (!main_rst_n)
    mc <= m_cur); // R7
  AST_BYPASS_NO_MODSEL: assert property (@(posedge clk_in) disable iff (!main_rst_n)
    bypass_cur |-> !mod_sel); // R4
  AST_DIRECT_M_MASK: assert property (@(posedge clk_in) disable iff (!main_rst_n)
    direct_cur |-> (m_cur[M_W-1:M_W-2] == 2'b00)); // R6
  AST_DIRECT_R_MASK: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ref_direct_cur |-> (r_cur[R_W-1:R_W-2] == 2'b00)); // R6
  AST_REF_BOUND: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    rc <= r_cur); // R5
endmodule

bind pulse_swallow_divider psd_checker #(
  .M_W(M_W), .A_W(A_W), .R_W(R_W), .PRE_LO(PRE_LO)
) u_psd_checker (
  .clk_in         (clk_in),
  .ref_clk        (ref_clk),
  .main_rst_n     (main_rst_n),
  .ref_rst_n      (ref_rst_n),
  .main_pulse     (main_pulse),
  .mod_sel        (mod_sel),
  .bypass_cur     (bypass_cur),
  .direct_cur     (direct_cur),
  .m_cur          (m_cur),
  .a_cur          (a_cur),
  .mc             (mc),
  .sw             (sw),
  .pc             (pc),
  .ref_direct_cur (ref_direct_cur),
  .r_cur          (r_cur),
  .rc             (rc)
);

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;
  logic       clk_in  = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic [8:0] m_val;
  logic [3:0] a_val;
  logic [5:0] r_val;
  logic       presc_en_n;
  logic       direct_mode;
  logic       main_pulse;
  logic       ref_pulse;
  logic       mod_sel;

  always #4 clk_in  = ~clk_in;   // 125 MHz
  always #6 ref_clk = ~ref_clk;

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk_in      (clk_in),
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .m_val       (m_val),
    .a_val       (a_val),
    .r_val       (r_val),
    .presc_en_n  (presc_en_n),
    .direct_mode (direct_mode),
    .main_pulse  (main_pulse),
    .ref_pulse   (ref_pulse),
    .mod_sel     (mod_sel)
  );

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // scoreboard queues
  int    main_per_q[$];
  int    main_hi_q[$];
  string main_tag_q[$];
  int    ref_per_q[$];
  string ref_tag_q[$];

  int main_cyc = 0;
  int main_hi  = 0;
  int ref_cyc  = 0;
  event main_ev;
  event ref_ev;

  int prev_main_per;
  int prev_main_hi;
  int prev_ref_per;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // main monitor: measures period and mod_sel-high cycles between pulses
  initial begin
    forever begin
      @(negedge clk_in);
      if (rst_n && main_pulse) begin
        if (main_per_q.size() > 0) begin
          int    ep;
          int    eh;
          string tg;
          ep = main_per_q.pop_front();
          eh = main_hi_q.pop_front();
          tg = main_tag_q.pop_front();
          check(main_cyc == ep, tg, "main period", main_cyc, ep);
          check(main_hi == eh, tg, "mod_sel high cycles", main_hi, eh);
        end
        main_cyc = 1;
        main_hi  = mod_sel ? 1 : 0;
        -> main_ev;
      end else begin
        main_cyc++;
        if (mod_sel) main_hi++;
      end
    end
  end

  // reference monitor
  initial begin
    forever begin
      @(negedge ref_clk);
      if (rst_n && ref_pulse) begin
        if (ref_per_q.size() > 0) begin
          int    ep;
          string tg;
          ep = ref_per_q.pop_front();
          tg = ref_tag_q.pop_front();
          check(ref_cyc == ep, tg, "ref period", ref_cyc, ep);
        end
        ref_cyc = 1;
        -> ref_ev;
      end else begin
        ref_cyc++;
      end
    end
  end

  // driver: change settings right after a pulse; the running period keeps
  // the old ratio (R7), the following ones use the new ratio
  task automatic run_main(input int m, input int a, input bit byp,
                          input bit dir, input string tag);
    int m_eff;
    int per;
    int hi;
    m_eff = dir ? (m % 128) : m;
    per   = byp ? (m_eff + 1) : (10 * (m_eff + 1) + a);
    hi    = byp ? 0 : 11 * a;
    @(main_ev);
    m_val       = 9'(m);
    a_val       = 4'(a);
    presc_en_n  = byp;
    direct_mode = dir;
    main_per_q.push_back(prev_main_per); main_hi_q.push_back(prev_main_hi);
    main_tag_q.push_back("R7 old ratio kept");
    main_per_q.push_back(per); main_hi_q.push_back(hi); main_tag_q.push_back(tag);
    main_per_q.push_back(per); main_hi_q.push_back(hi); main_tag_q.push_back(tag);
    prev_main_per = per;
    prev_main_hi  = hi;
    while (main_per_q.size() != 0) @(negedge clk_in);
  endtask

  task automatic run_ref(input int r, input bit dir, input string tag);
    int per;
    per = (dir ? (r % 16) : r) + 1;
    @(ref_ev);
    r_val       = 6'(r);
    direct_mode = dir;
    ref_per_q.push_back(prev_ref_per); ref_tag_q.push_back("R7 old ref ratio kept");
    ref_per_q.push_back(per); ref_tag_q.push_back(tag);
    ref_per_q.push_back(per); ref_tag_q.push_back(tag);
    prev_ref_per = per;
    while (ref_per_q.size() != 0) @(negedge ref_clk);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk_in);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    m_val       = 9'd1;
    a_val       = 4'd0;
    r_val       = 6'd0;
    presc_en_n  = 1'b0;
    direct_mode = 1'b0;
    prev_main_per = 20;
    prev_main_hi  = 0;
    prev_ref_per  = 1;
    repeat (5) @(negedge clk_in);
    // R8: quiet outputs during reset
    check(main_pulse == 1'b0, "R8", "main_pulse in reset", main_pulse, 0);
    check(ref_pulse == 1'b0, "R8", "ref_pulse in reset", ref_pulse, 0);
    check(mod_sel == 1'b0, "R8", "mod_sel in reset", mod_sel, 0);
    rst_n = 1'b1;

    run_main(1, 0, 1'b0, 1'b0, "R3 M=1 prescaled");
    run_main(1, 2, 1'b0, 1'b0, "R1 A=M+1");
    run_main(5, 3, 1'b0, 1'b0, "R2 swallow 3");
    run_main(511, 15, 1'b0, 1'b0, "R1 max ratio");
    run_main(1, 7, 1'b1, 1'b0, "R4 R3 bypass M=1 A ignored");
    run_main(200, 9, 1'b1, 1'b0, "R4 bypass");
    run_main(300, 4, 1'b0, 1'b1, "R6 direct M mask");
    run_main(511, 3, 1'b1, 1'b1, "R6 direct bypass");
    for (int i = 0; i < 4; i++) begin
      int m;
      int amax;
      m    = 1 + $urandom_range(62);
      amax = (m + 1 > 15) ? 15 : m + 1;
      run_main(m, $urandom_range(amax), 1'b0, 1'b0, "R1 R2 random");
    end
    for (int i = 0; i < 2; i++) begin
      run_main(1 + $urandom_range(510), $urandom_range(15), 1'b1, 1'b0, "R4 random");
    end

    run_ref(0, 1'b0, "R5 R=0 passthrough");
    run_ref(63, 1'b0, "R5 max");
    run_ref(5, 1'b0, "R5 mid");
    run_ref(50, 1'b1, "R6 direct R mask");
    run_ref(0, 1'b0, "R5 back to zero");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule